// File: doc/BRIEF.md
# Multi-Policy System Bus Arbiter

This block decides which of four processors owns a shared system bus. Each processor raises its own request line and receives its own grant line. A busy output is high whenever any grant is active. A three-bit policy input selects how a winner is picked. Two policies use a fixed order: one resolves through a rippling priority chain and one resolves all requests in a single level. Three policies change the order as the system runs: a rotating ring, a ring with a bounded time slot per owner, and a least-recently-served order.

A grant is only ever issued from an idle bus. Once an owner has the bus, it keeps it for as long as it holds its request. The exception is the time-slice policy, where the owner can lose the bus to a waiting requester. When ownership ends, the bus stays idle for at least one cycle before the next winner is granted. The rotating pointer and the recency order are updated on every grant, whichever policy chose it, so the dynamic policies always start from the true grant history.

Top module: `sysbus_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `gnt_o` is all zero and `busy_o` is low. Reset sets the rotating highest-priority position to index 0 and the recency order to 0 (oldest), 1, 2, 3 (newest).
- R2: At most one bit of `gnt_o` is ever set, and `busy_o` is high exactly when one bit is set.
- R3: When the bus is idle at a rising edge and at least one request is high, that edge grants one of the requesting indices. With no request the bus stays idle. A grant never moves straight from one owner to another.
- R4: In every policy except time slice, an owner keeps its grant for as long as its request stays high, even when other requests are waiting. The edge after the owner's request is seen low clears the grant and `busy_o`, and the next grant comes at the following edge at the earliest.
- R5: `policy_i` = 0 (serial chain), and the unused codes 5, 6 and 7, grant the lowest requesting index.
- R6: `policy_i` = 1 (single-level fixed priority) grants the lowest requesting index.
- R7: `policy_i` = 2 (rotating) searches upward from the index after the most recently granted one, wrapping from 3 to 0.
- R8: `policy_i` = 3 (time slice) picks its winner in the same order as R7. An owner that has held the bus for SLICE_LEN cycles (default 4) loses its grant at the next edge if another request is high.
- R9: In time-slice mode, an owner with no other requester waiting keeps the grant past SLICE_LEN cycles.
- R10: `policy_i` = 4 (least recently used) grants the requesting index that was granted longest ago. The recency order is the one reset sets up, updated by later grants.
- R11: The rotating position and the recency order are updated on every grant, whichever policy issued it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 4 | One bus request per processor, bit i = processor i |
| policy_i | input | 3 | Arbitration policy: 0 serial, 1 single-level, 2 rotating, 3 time slice, 4 least recently used, 5..7 as 0 |
| gnt_o | output | 4 | One-hot grant, bit i = processor i owns the bus |
| busy_o | output | 1 | High while any processor holds the bus |

## Verification
The hardest case to reach is a time-slice revocation. It needs an owner that is still requesting, a slot counter that has run to its limit, and a second request present on the same edge. The counter is hidden state, reachable only by holding a grant for the exact number of cycles. The bench first grants one processor with a second one already waiting. It then counts edges from the observed grant and checks that the grant holds for exactly SLICE_LEN cycles, that the bus goes idle, and that the waiting processor wins next. The dynamic policies depend on every earlier grant, so the vector table runs policies in a fixed order. Each expected winner is derived by hand from the pointer and recency order that the earlier vectors leave behind.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [2:0] {
        POL_SERIAL   = 3'd0,
        POL_PARALLEL = 3'd1,
        POL_ROTATE   = 3'd2,
        POL_SLICE    = 3'd3,
        POL_LRU      = 3'd4
    } sba_policy_e;

    // Unused codes fall back to the serial fixed order.
    function automatic sba_policy_e decode_policy(input logic [2:0] code);
        case (code)
            3'd1:    return POL_PARALLEL;
            3'd2:    return POL_ROTATE;
            3'd3:    return POL_SLICE;
            3'd4:    return POL_LRU;
            default: return POL_SERIAL;
        endcase
    endfunction

    // Conditions seen while an owner holds the bus.
    typedef struct packed {
        logic owner_req;
        logic contend;
        logic expired;
    } hold_ctx_t;

endpackage

// File: rtl/sba_fixed_pick.sv
module sba_fixed_pick #(
    parameter int NUM_REQ = 4,
    parameter bit CHAIN   = 1'b1
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] pick
);
    localparam logic [NUM_REQ-1:0] ONE = NUM_REQ'(1);

    generate
        if (CHAIN) begin : g_chain
            // Each stage passes an inhibit to the stages above it.
            logic [NUM_REQ-1:0] blocked;
            assign blocked[0] = 1'b0;
            for (genvar i = 0; i < NUM_REQ; i++) begin : g_stage
                assign pick[i] = req[i] & ~blocked[i];
                if (i + 1 < NUM_REQ) begin : g_link
                    assign blocked[i+1] = blocked[i] | req[i];
                end
            end
        end else begin : g_flat
            // Isolate the lowest set bit in one level.
            assign pick = req & (~req + ONE);
        end
    endgenerate
endmodule

// File: rtl/sba_rot_pick.sv
module sba_rot_pick #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:0] ptr_oh,
    output logic [NUM_REQ-1:0] pick
);
    localparam logic [NUM_REQ-1:0] ONE = NUM_REQ'(1);

    logic [NUM_REQ-1:0] upper_mask;
    logic [NUM_REQ-1:0] upper_req;
    logic [NUM_REQ-1:0] src;

    always_comb begin
        upper_mask = ~(ptr_oh - ONE);
        upper_req  = req & upper_mask;
        src        = (upper_req != '0) ? upper_req : req;
        pick       = src & (~src + ONE);
    end
endmodule

// File: rtl/sba_lru.sv
module sba_lru #(
    parameter int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:0] upd_oh,
    output logic [NUM_REQ-1:0] pick
);
    localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    // Rank 0 = granted longest ago, NUM_REQ-1 = granted last.
    logic [RW-1:0] rank_q [NUM_REQ];
    logic [RW-1:0] upd_rank;

    always_comb begin
        upd_rank = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            upd_rank = upd_rank | (rank_q[i] & {RW{upd_oh[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                rank_q[i] <= RW'(i);
            end
        end else if (upd_oh != '0) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                if (upd_oh[i]) begin
                    rank_q[i] <= RW'(NUM_REQ - 1);
                end else if (rank_q[i] > upd_rank) begin
                    rank_q[i] <= rank_q[i] - 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_REQ; i++) begin
            pick[i] = req[i];
            for (int j = 0; j < NUM_REQ; j++) begin
                if (j != i && req[j] && (rank_q[j] < rank_q[i])) begin
                    pick[i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sba_slice_timer.sv
module sba_slice_timer #(
    parameter int SLICE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = (SLICE_LEN > 1) ? $clog2(SLICE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLICE_LEN - 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
    import sba_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int SLICE_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [2:0]         policy_i,
    output logic [NUM_REQ-1:0] gnt_o,
    output logic               busy_o
);
    localparam logic [NUM_REQ-1:0] NONE     = '0;
    localparam logic [NUM_REQ-1:0] PTR_INIT = NUM_REQ'(1);

    sba_policy_e        pol;
    logic [NUM_REQ-1:0] gnt_q, gnt_d;
    logic [NUM_REQ-1:0] ptr_oh;
    logic [NUM_REQ-1:0] pick_ser, pick_par, pick_rot, pick_lru;
    logic [NUM_REQ-1:0] cand, issue_oh;
    logic               bus_idle;
    logic               slice_expired;
    hold_ctx_t          ctx;

    assign pol = decode_policy(policy_i);

    sba_fixed_pick #(.NUM_REQ(NUM_REQ), .CHAIN(1'b1)) u_ser (
        .req (req_i),
        .pick(pick_ser)
    );

    sba_fixed_pick #(.NUM_REQ(NUM_REQ), .CHAIN(1'b0)) u_par (
        .req (req_i),
        .pick(pick_par)
    );

    sba_rot_pick #(.NUM_REQ(NUM_REQ)) u_rot (
        .req   (req_i),
        .ptr_oh(ptr_oh),
        .pick  (pick_rot)
    );

    sba_lru #(.NUM_REQ(NUM_REQ)) u_lru (
        .clk   (clk),
        .rst   (rst),
        .req   (req_i),
        .upd_oh(issue_oh),
        .pick  (pick_lru)
    );

    sba_slice_timer #(.SLICE_LEN(SLICE_LEN)) u_slice (
        .clk    (clk),
        .rst    (rst),
        .start  (issue_oh != NONE),
        .run    (!bus_idle),
        .expired(slice_expired)
    );

    always_comb begin
        case (pol)
            POL_PARALLEL:        cand = pick_par;
            POL_ROTATE,
            POL_SLICE:           cand = pick_rot;
            POL_LRU:             cand = pick_lru;
            default:             cand = pick_ser;
        endcase
    end

    assign bus_idle = (gnt_q == NONE);
    assign issue_oh = bus_idle ? cand : NONE;

    always_comb begin
        ctx.owner_req = |(req_i & gnt_q);
        ctx.contend   = |(req_i & ~gnt_q);
        ctx.expired   = slice_expired;
    end

    always_comb begin
        if (bus_idle) begin
            gnt_d = cand;
        end else if (!ctx.owner_req) begin
            gnt_d = NONE;
        end else if (pol == POL_SLICE && ctx.expired && ctx.contend) begin
            gnt_d = NONE;
        end else begin
            gnt_d = gnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q  <= NONE;
            ptr_oh <= PTR_INIT;
        end else begin
            gnt_q <= gnt_d;
            if (issue_oh != NONE) begin
                ptr_oh <= {issue_oh[NUM_REQ-2:0], issue_oh[NUM_REQ-1]};
            end
        end
    end

    assign gnt_o  = gnt_q;
    assign busy_o = !bus_idle;
endmodule

// File: rtl/sysbus_arbiter_chk.sv
module sysbus_arbiter_chk #(
    parameter int NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_i,
    input logic [2:0]         policy_i,
    input logic [NUM_REQ-1:0] gnt_o,
    input logic               busy_o
);
    AST_ONEHOT_GNT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));  // R2

    AST_GRANT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((gnt_o != '0) && (gnt_o != $past(gnt_o))) |-> !$past(busy_o));  // R3

    AST_IDLE_SERVES_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (req_i != '0)) |=> ((gnt_o & $past(req_i)) != '0));  // R3

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (req_i == '0)) |=> !busy_o);  // R3

    AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ((req_i & gnt_o) != '0) && (policy_i != 3'd3)) |=> (gnt_o == $past(gnt_o)));  // R4

    AST_RELEASE_IDLES: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ((req_i & gnt_o) == '0)) |=> !busy_o);  // R4

    AST_SLICE_ALONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (policy_i == 3'd3) && (req_i == gnt_o)) |=> (gnt_o == $past(gnt_o)));  // R9
endmodule

bind sysbus_arbiter sysbus_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .policy_i(policy_i),
    .gnt_o   (gnt_o),
    .busy_o  (busy_o)
);

// File: tb/sysbus_arbiter_bench.sv
`timescale 1ns/1ps
module sysbus_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = 4'b0000;
    logic [2:0] pol = 3'd0;
    logic [3:0] gnt;
    logic       busy;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    sysbus_arbiter #(.NUM_REQ(4), .SLICE_LEN(4)) u_sysbus_arbiter (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .policy_i(pol),
        .gnt_o   (gnt),
        .busy_o  (busy)
    );

    // {policy, request pattern from idle bus, expected grant}
    localparam int NV = 11;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 4'b1110, 4'b0010},  // R5 serial
        {3'd1, 4'b1100, 4'b0100},  // R6 single level
        {3'd1, 4'b1111, 4'b0001},  // R6
        {3'd2, 4'b1111, 4'b0010},  // R7 R11: pointer moved by the parallel grant
        {3'd2, 4'b0011, 4'b0001},  // R7 wrap
        {3'd2, 4'b1001, 4'b1000},  // R7
        {3'd4, 4'b1011, 4'b0010},  // R10 R11
        {3'd4, 4'b1111, 4'b0100},  // R10
        {3'd4, 4'b1010, 4'b1000},  // R10
        {3'd3, 4'b0110, 4'b0010},  // R8 order as rotating
        {3'd7, 4'b1100, 4'b0100}   // R5 unused code
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything off even with requests present
        req = 4'b1111;
        repeat (3) step();
        chk("R1 gnt in reset", gnt, 4'b0000);
        chk("R1 busy in reset", {3'b000, busy}, 4'b0000);
        req = 4'b0000;
        rst = 1'b0;
        step();
        chk("R1 gnt after reset", gnt, 4'b0000);
        chk("R3 idle without requests", {3'b000, busy}, 4'b0000);

        for (int v = 0; v < NV; v++) begin
            pol = VEC[v][10:8];
            req = VEC[v][7:4];
            step();
            chk($sformatf("R3 vector %0d grant", v), gnt, VEC[v][3:0]);
            chk($sformatf("R2 vector %0d busy", v), {3'b000, busy}, 4'b0001);
            req = 4'b0000;
            step();
            chk($sformatf("R4 vector %0d release", v), gnt, 4'b0000);
        end

        // R4: owner keeps bus against a higher fixed priority, then an idle gap
        pol = 3'd0;
        req = 4'b0100;
        step();
        chk("R4 grant idx2", gnt, 4'b0100);
        req = 4'b0101;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4 hold vs idx0", gnt, 4'b0100);
        end
        req = 4'b0001;
        step();
        chk("R4 idle gap", {gnt[3:1], busy}, 4'b0000);
        step();
        chk("R5 idx0 after gap", gnt, 4'b0001);
        req = 4'b0000;
        step();

        // R8: slice revocation with a waiting requester
        pol = 3'd3;
        req = 4'b0011;
        step();
        chk("R8 slice grant idx1", gnt, 4'b0010);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 within slice", gnt, 4'b0010);
        end
        step();
        chk("R8 revoked", {gnt[3:1], busy}, 4'b0000);
        step();
        chk("R8 next in ring", gnt, 4'b0001);
        req = 4'b0000;
        step();

        // R9: lone owner keeps the bus past the slice
        req = 4'b0100;
        step();
        chk("R9 grant idx2", gnt, 4'b0100);
        for (int k = 0; k < 10; k++) begin
            step();
            chk("R9 kept without contender", gnt, 4'b0100);
        end
        req = 4'b0000;
        step();

        // R4: rotating mode never preempts
        pol = 3'd2;
        req = 4'b0011;
        step();
        chk("R7 rotate wraps to idx0", gnt, 4'b0001);
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R4 rotate hold", gnt, 4'b0001);
        end
        req = 4'b0000;
        step();

        // R1: reset while owned clears grant and priority state
        pol = 3'd0;
        req = 4'b0100;
        step();
        chk("R5 grant before reset", gnt, 4'b0100);
        rst = 1'b1;
        step();
        chk("R1 reset drops grant", gnt, 4'b0000);
        pol = 3'd2;
        req = 4'b1111;
        rst = 1'b0;
        step();
        chk("R1 pointer back at idx0", gnt, 4'b0001);
        req = 4'b0000;
        step();
        pol = 3'd4;
        req = 4'b1110;
        step();
        chk("R10 R1 order after reset", gnt, 4'b0010);
        req = 4'b0000;
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule